// File: doc/BRIEF.md
# Start Frame Delimiter Search with Acquisition Timeout

This receive-side block sits behind the despreader and watches the demodulated DBPSK bit stream, one bit per symbol strobe. Once the acquisition logic signals that spreading-code lock has been reached, the block hunts for a configured 16-bit start frame delimiter (SFD). A programmable symbol count bounds the hunt. The count starts at the lock pulse, and a fresh lock pulse during the hunt starts it over.

When the delimiter matches, the block fixes frame timing and collects the 8-bit signal field that follows. From that field it decides which demodulator the payload needs: DBPSK, DQPSK, binary orthogonal keying or quadrature orthogonal keying. If the hunt runs out of time, the block reports a timeout and drops back to idle. An unknown signal value ends the packet with an error pulse. A packet is never declared unless the delimiter was found.

The controller is a three-state machine. IDLE waits for lock. HUNT shifts bits in and compares them. SIGNAL collects the eight signal bits. The named transitions are:

- ACQUIRE: IDLE to HUNT on a lock pulse.
- RESTART: HUNT to HUNT on a lock pulse. This clears the timer and the partial pattern.
- SFD_FOUND: HUNT to SIGNAL.
- EXPIRE: HUNT to IDLE when the limit is reached with no match.
- DECIDE: SIGNAL to IDLE after the eighth signal bit. This emits either a valid packet or a header error.

Top module: `sfd_hunt`

## Requirements
- R1: In IDLE, strobed bits are ignored. A `pn_lock` pulse (ACQUIRE) starts the hunt, and only bits strobed after that pulse take part in it.
- R2: The delimiter matches only when the last 16 strobed bits since acquisition equal `sfd_pattern` exactly. The earliest-received of those bits corresponds to bit 15 and the newest to bit 0. No match is possible before 16 bits have been received since acquisition.
- R3: `pkt_valid` is never raised unless a delimiter match preceded it in the same hunt. Bits sent without acquisition, or after a timeout, never produce a packet.
- R4: With `tmo_limit` = T > 0, `srch_to` pulses for one cycle after the T-th symbol strobe since the latest acquisition if no match occurred. No pulse occurs before that strobe. The block then returns to IDLE.
- R5: `tmo_limit` = 0 disables the timeout, and the hunt runs indefinitely.
- R6: A `pn_lock` pulse during HUNT (RESTART) restarts the symbol count and discards all partially received delimiter bits.
- R7: After a match, the next 8 strobed bits form the signal field, most significant bit first. The values 0Ah, 14h, 37h and 6Eh give `rate_mode` 00 (DBPSK), 01 (DQPSK), 10 (binary orthogonal keying) and 11 (quadrature orthogonal keying). `pkt_valid` pulses for one cycle, and `rate_mode` takes the new code in the same cycle and holds it until the next valid packet.
- R8: Any other signal value gives a one-cycle `hdr_err` pulse instead of `pkt_valid` and leaves `rate_mode` unchanged. At most one of `pkt_valid`, `srch_to` and `hdr_err` is high in any cycle.
- R9: If the strobe that completes a match is also the T-th strobe, the match wins and no timeout is reported.
- R10: After reset the block is in IDLE, all three pulses are low and `rate_mode` is 00.
- R11: `bit_in` is ignored in cycles where `bit_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Demodulated data bit |
| bit_stb | input | 1 | Qualifies `bit_in`; one strobe per symbol |
| pn_lock | input | 1 | One-cycle pulse on spreading-code acquisition |
| sfd_pattern | input | SFD_W | Delimiter pattern to match |
| tmo_limit | input | TMO_W | Hunt limit in symbols; 0 disables the timeout |
| pkt_valid | output | 1 | One-cycle pulse when a packet header is accepted |
| srch_to | output | 1 | One-cycle pulse when the hunt times out |
| hdr_err | output | 1 | One-cycle pulse when the signal field is unknown |
| rate_mode | output | 2 | Payload demodulation code from the last valid header |

## Verification
Every result is registered once. `pkt_valid`, `hdr_err` and the new `rate_mode` appear in the cycle right after the clock edge that takes the eighth signal bit. `srch_to` appears in the cycle after the edge that takes the T-th strobe, and the state change after a lock pulse takes effect at the next edge. The bench drives each strobe on a falling edge, releases it at the next falling edge, and samples all outputs at that same falling edge, so each result is read exactly one edge after the stimulus. Pulses are also accumulated over each sequence, so a pulse that arrives early or at the wrong time is caught even when the final sample is correct.

// File: rtl/sfd_hunt_pkg.sv
package sfd_hunt_pkg;

    localparam int SIG_W   = 8;
    localparam int N_RATES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_SIG  = 2'd2
    } hunt_st_t;

    typedef enum logic [1:0] {
        MODE_DBPSK = 2'b00,
        MODE_DQPSK = 2'b01,
        MODE_BOK   = 2'b10,
        MODE_QOK   = 2'b11
    } rate_mode_t;

    // signal field value for each rate code, indexed by the code
    localparam logic [SIG_W-1:0] SIG_CODE [N_RATES] = '{8'h0A, 8'h14, 8'h37, 8'h6E};

endpackage

// File: rtl/sfd_shifter.sv
module sfd_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    output logic         hit_nx
);
    localparam int FW = $clog2(W + 1);

    logic [W-1:0]  sr_q;
    logic [W-1:0]  sr_nx;
    logic [FW-1:0] fill_q;
    logic          full_nx;

    assign sr_nx   = {sr_q[W-2:0], bit_in};
    assign full_nx = (fill_q >= FW'(W - 1));
    // match that would result if the present bit were shifted in
    assign hit_nx  = full_nx && (sr_nx == pattern);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (clr) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (shift) begin
            sr_q <= sr_nx;
            if (fill_q != FW'(W))
                fill_q <= fill_q + 1'b1;
        end
    end

endmodule

// File: rtl/sym_timer.sv
module sym_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          last_nx
);
    logic [TW-1:0] cnt_q;

    // true when the present tick would be the limit-th one
    assign last_nx = (limit != '0) && (cnt_q >= (limit - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sig_decode.sv
module sig_decode
    import sfd_hunt_pkg::*;
(
    input  logic [SIG_W-1:0] field,
    output logic             known,
    output rate_mode_t       mode
);
    always_comb begin
        known = 1'b0;
        mode  = MODE_DBPSK;
        for (int i = 0; i < N_RATES; i++) begin
            if (field == SIG_CODE[i]) begin
                known = 1'b1;
                mode  = rate_mode_t'(2'(i));
            end
        end
    end

endmodule

// File: rtl/sfd_hunt.sv
module sfd_hunt
    import sfd_hunt_pkg::*;
#(
    parameter int SFD_W = 16,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_stb,
    input  logic             pn_lock,
    input  logic [SFD_W-1:0] sfd_pattern,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             pkt_valid,
    output logic             srch_to,
    output logic             hdr_err,
    output logic [1:0]       rate_mode
);
    localparam int SCW = $clog2(SIG_W);

    hunt_st_t state_q, state_d;

    logic sh_clr, sh_shift, sfd_hit_nx;
    logic tm_clr, tm_tick, tmo_last_nx;
    logic sig_clr, sig_shift;
    logic to_ev, fin_ev;

    logic [SIG_W-1:0] sig_q, sig_nx;
    logic [SCW-1:0]   sig_cnt_q;
    logic             sig_known;
    rate_mode_t       sig_mode;

    sfd_shifter #(.W(SFD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sh_clr),
        .shift   (sh_shift),
        .bit_in  (bit_in),
        .pattern (sfd_pattern),
        .hit_nx  (sfd_hit_nx)
    );

    sym_timer #(.TW(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tm_clr),
        .tick    (tm_tick),
        .limit   (tmo_limit),
        .last_nx (tmo_last_nx)
    );

    assign sig_nx = {sig_q[SIG_W-2:0], bit_in};

    sig_decode u_dec (
        .field (sig_nx),
        .known (sig_known),
        .mode  (sig_mode)
    );

    // next state and datapath controls
    always_comb begin
        state_d   = state_q;
        sh_clr    = 1'b0;
        sh_shift  = 1'b0;
        tm_clr    = 1'b0;
        tm_tick   = 1'b0;
        sig_clr   = 1'b0;
        sig_shift = 1'b0;
        to_ev     = 1'b0;
        fin_ev    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pn_lock) begin                  // ACQUIRE
                    state_d = ST_HUNT;
                    sh_clr  = 1'b1;
                    tm_clr  = 1'b1;
                end
            end
            ST_HUNT: begin
                if (pn_lock) begin                  // RESTART
                    sh_clr = 1'b1;
                    tm_clr = 1'b1;
                end else if (bit_stb) begin
                    sh_shift = 1'b1;
                    tm_tick  = 1'b1;
                    if (sfd_hit_nx) begin           // SFD_FOUND
                        state_d = ST_SIG;
                        sig_clr = 1'b1;
                    end else if (tmo_last_nx) begin // EXPIRE
                        state_d = ST_IDLE;
                        to_ev   = 1'b1;
                    end
                end
            end
            ST_SIG: begin
                if (bit_stb) begin
                    sig_shift = 1'b1;
                    if (sig_cnt_q == SCW'(SIG_W - 1)) begin // DECIDE
                        state_d = ST_IDLE;
                        fin_ev  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // signal field collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q     <= '0;
            sig_cnt_q <= '0;
        end else if (sig_clr) begin
            sig_q     <= '0;
            sig_cnt_q <= '0;
        end else if (sig_shift) begin
            sig_q     <= sig_nx;
            sig_cnt_q <= sig_cnt_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            srch_to   <= 1'b0;
            hdr_err   <= 1'b0;
            rate_mode <= MODE_DBPSK;
        end else begin
            pkt_valid <= 1'b0;
            srch_to   <= to_ev;
            hdr_err   <= 1'b0;
            if (fin_ev) begin
                if (sig_known) begin
                    pkt_valid <= 1'b1;
                    rate_mode <= sig_mode;
                end else begin
                    hdr_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sfd_hunt_chk.sv
module sfd_hunt_chk
    import sfd_hunt_pkg::*;
#(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hunt_st_t         state,
    input  logic             pn_lock,
    input  logic             pkt_valid,
    input  logic             srch_to,
    input  logic             hdr_err,
    input  logic [1:0]       rate_mode,
    input  logic [TMO_W-1:0] tmo_limit
);
    AST_ACQUIRE_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pn_lock) |=> (state == ST_HUNT)); // R1

    AST_VALID_AFTER_SFD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> ($past(state) == ST_SIG)); // R3

    AST_TIMEOUT_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        srch_to |-> ($past(state) == ST_HUNT && state == ST_IDLE)); // R4

    AST_NO_TIMEOUT_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        srch_to |-> ($past(tmo_limit) != '0)); // R5

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> $stable(rate_mode)); // R7

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_valid, srch_to, hdr_err})); // R8

endmodule

bind sfd_hunt sfd_hunt_chk #(.TMO_W(TMO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .pn_lock   (pn_lock),
    .pkt_valid (pkt_valid),
    .srch_to   (srch_to),
    .hdr_err   (hdr_err),
    .rate_mode (rate_mode),
    .tmo_limit (tmo_limit)
);

// File: tb/sim_sfd_hunt.sv
`timescale 1ns/1ps
module sim_sfd_hunt;

    localparam int SFD_W = 16;
    localparam int TMO_W = 12;
    localparam logic [15:0] PAT = 16'h05CF;  // MSB 0: a run of ones in front cannot alias it

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0, bit_stb = 1'b0, pn_lock = 1'b0;
    logic [SFD_W-1:0] sfd_pattern = PAT;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic pkt_valid, srch_to, hdr_err;
    logic [1:0] rate_mode;

    int checks = 0;
    int errors = 0;
    logic last_v, last_t, last_e;
    logic any_v, any_t, any_e;
    logic [1:0] mode_exp = 2'b00;

    always #2.5 clk = ~clk;

    sfd_hunt #(.SFD_W(SFD_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
        .pn_lock(pn_lock), .sfd_pattern(sfd_pattern), .tmo_limit(tmo_limit),
        .pkt_valid(pkt_valid), .srch_to(srch_to), .hdr_err(hdr_err),
        .rate_mode(rate_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_any();
        any_v = 1'b0; any_t = 1'b0; any_e = 1'b0;
    endtask

    task automatic strobe(input logic b);
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; bit_in = 1'b0;
        last_v = pkt_valid; last_t = srch_to; last_e = hdr_err;
        any_v |= pkt_valid; any_t |= srch_to; any_e |= hdr_err;
    endtask

    task automatic acquire();
        pn_lock = 1'b1;
        @(negedge clk);
        pn_lock = 1'b0;
        clear_any();
    endtask

    task automatic send16(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) strobe(w[i]);
    endtask

    task automatic send8(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) strobe(w[i]);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) strobe(1'b1);
    endtask

    function automatic int exp_code(input logic [7:0] v);
        case (v)
            8'h0A: return 0;
            8'h14: return 1;
            8'h37: return 2;
            8'h6E: return 3;
            default: return -1;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        clear_any();
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!pkt_valid && !srch_to && !hdr_err && rate_mode == 2'b00, "R10", int'(rate_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pkt_valid && !srch_to && !hdr_err, "R10", int'(pkt_valid), 0);

        // R1 / R3: no acquisition, full header yields nothing
        clear_any();
        ones(20); send16(PAT); send8(8'h0A);
        check(!any_v && !any_e && !any_t, "R1", int'(any_v), 0);

        // R7 / R8: sweep every signal value
        tmo_limit = '0;
        for (int v = 0; v < 256; v++) begin
            sfd_pattern = 16'h1D6B ^ {8'(v), 8'(v)};
            acquire();
            send16(sfd_pattern);
            check(!any_v && !any_e && !any_t, "R2", int'(any_v), 0);
            send8(8'(v));
            if (exp_code(8'(v)) >= 0) begin
                mode_exp = 2'(exp_code(8'(v)));
                check(last_v && !last_e, "R7", int'(last_v), 1);
                check(rate_mode == mode_exp, "R7", int'(rate_mode), int'(mode_exp));
            end else begin
                check(last_e && !last_v, "R8", int'(last_e), 1);
                check(rate_mode == mode_exp, "R8", int'(rate_mode), int'(mode_exp));
            end
            @(negedge clk);
            check(!pkt_valid && !hdr_err, "R8", int'(pkt_valid | hdr_err), 0);
        end

        // R2: all-zero pattern needs 16 bits before matching
        sfd_pattern = 16'h0000;
        acquire();
        send16(16'h0000); send8(8'h14);
        check(last_v && !any_e && rate_mode == 2'b01, "R2", int'(rate_mode), 1);
        mode_exp = 2'b01;

        // R4: timeout sweep
        sfd_pattern = PAT;
        for (int t = 1; t <= 12; t++) begin
            tmo_limit = TMO_W'(t);
            acquire();
            for (int k = 1; k < t; k++) strobe(1'b0);
            check(!any_t, "R4", int'(any_t), 0);
            strobe(1'b0);
            check(last_t, "R4", int'(last_t), 1);
            clear_any();
            tmo_limit = '0;
            ones(20); send16(PAT); send8(8'h0A);
            check(!any_v && !any_t && !any_e, "R4", int'(any_v), 0);
        end

        // R5: zero limit never times out
        tmo_limit = '0;
        acquire();
        for (int k = 0; k < 300; k++) strobe(1'b0);
        check(!any_t, "R5", int'(any_t), 0);
        ones(20); send16(PAT); send8(8'h37);
        check(last_v && rate_mode == 2'b10, "R5", int'(rate_mode), 2);
        mode_exp = 2'b10;

        // R6: restart of the count
        tmo_limit = TMO_W'(10);
        acquire();
        for (int k = 0; k < 7; k++) strobe(1'b0);
        pn_lock = 1'b1; @(negedge clk); pn_lock = 1'b0;
        for (int k = 0; k < 9; k++) strobe(1'b0);
        check(!any_t, "R6", int'(any_t), 0);
        strobe(1'b0);
        check(last_t, "R6", int'(last_t), 1);

        // R6: restart discards partial delimiter
        tmo_limit = '0;
        acquire();
        ones(20);
        for (int i = 15; i >= 8; i--) strobe(PAT[i]);
        pn_lock = 1'b1; @(negedge clk); pn_lock = 1'b0;
        for (int i = 7; i >= 0; i--) strobe(PAT[i]);
        send8(8'h0A);
        check(!any_v && !any_e, "R6", int'(any_v), 0);
        ones(20); send16(PAT); send8(8'h0A);
        check(last_v && rate_mode == 2'b00, "R6", int'(rate_mode), 0);
        mode_exp = 2'b00;

        // R9: match on the expiry strobe wins
        tmo_limit = TMO_W'(16);
        acquire();
        send16(PAT);
        check(!any_t, "R9", int'(any_t), 0);
        send8(8'h37);
        check(last_v && !any_t && rate_mode == 2'b10, "R9", int'(rate_mode), 2);
        mode_exp = 2'b10;

        // R11: bits without strobe are ignored
        tmo_limit = '0;
        acquire();
        for (int i = 15; i >= 0; i--) begin
            strobe(PAT[i]);
            bit_in = ~PAT[i];
            repeat (2) @(negedge clk);
            bit_in = 1'b0;
        end
        for (int i = 7; i >= 0; i--) begin
            bit_in = ~i[0];
            @(negedge clk);
            strobe(logic'((8'h6E >> i) & 8'h01));
        end
        check(last_v && !any_e && rate_mode == 2'b11, "R11", int'(rate_mode), 3);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule